// File: doc/BRIEF.md
# Clock-Calendar Update Engine

This block holds a seven-field time and calendar bank: seconds, minutes, hours, day of week, date, month and year. It advances the bank by one second every `TICK_DIV` pulses of a slow tick input, which is nominally 32.768 kHz. Each field is stored either as packed BCD or as plain binary. A mode pin selects the encoding, and every rollover decision is made in that encoding. Hours run in 24-hour form, or in 12-hour form with a PM flag in bit 7 of the hours byte. February gains its 29th day in every year that is a multiple of four.

A three-bit divider control runs, freezes or clears the prescaler. Clearing preloads the prescaler to its midpoint, so the first update after release lands half a second later. An update-pending output rises a fixed number of ticks before each update, so software can tell whether a read is safe. While the hold input is high, no update takes place and the fields accept writes through a simple select/data port.

The block has no data stream. All pins are plain control and status levels, sampled on the rising clock edge.

Top module: `rtc_update_engine`

## Requirements
- R1: With the divider control at 010 and hold low, an update happens exactly once per `TICK_DIV` tick pulses. Each update increments seconds; when seconds are 59, they wrap to 0 and minutes increment.
- R2: With `bin_mode` = 1, fields are plain binary (59 is 0x3B). With `bin_mode` = 0, fields are packed BCD (59 is 0x59). The seconds and minutes wrap at 59 in whichever encoding is selected.
- R3: With `hour24` = 1, hours count 0 to 23. An update at 23:59:59 sets hours to 0 and starts a new day.
- R4: With `hour24` = 0, hours bit 7 is PM (1) or AM (0) and bits 6:0 hold 1 to 12. The sequence is 11 to 12 with the PM flag toggled, then 12 to 1. The step from 11 PM to 12 AM starts a new day.
- R5: Day of week runs 1 to 7 and wraps from 7 to 1 at the start of each new day.
- R6: At a new day, the date wraps to 1 after the last day of its month. April, June, September and November have 30 days. February has 29 days when the year is a multiple of four, year 0 included, and 28 otherwise. All other months have 31 days.
- R7: When the date wraps, the month increments, and December wraps to January. January is 1 and December is 12. The month wrap increments the year, and year 99 wraps to 0.
- R8: Divider control 110 or 111 presets the prescaler to `TICK_DIV`/2. After a return to 010, the first update falls `TICK_DIV`/2 ticks later. Any other pattern freezes the prescaler, and no update occurs.
- R9: `uip_o` is high during exactly the last `UIP_LEAD` tick periods before each update and falls on the update edge. It is low while the divider is not at 010 or hold is high.
- R10: While `set_hold` = 1, no update occurs. While `set_hold` = 1, `wr_en` writes `wr_data` into the field picked by `wr_sel`: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year. With `set_hold` = 0, writes are ignored.
- R11: Seconds bit 7 always reads 0. A written bit 7 is dropped.
- R12: After reset, the fields read seconds 0, minutes 0, hours 0, day of week 1, date 1, month 1 and year 0, and `uip_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse per oscillator period |
| div_ctl | input | 3 | Divider control: 010 run, 11x preset to half, others freeze |
| set_hold | input | 1 | Suppresses updates and enables field writes |
| bin_mode | input | 1 | 1 binary, 0 BCD |
| hour24 | input | 1 | 1 for 24-hour, 0 for 12-hour with PM flag |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field selector (see R10) |
| wr_data | input | 8 | Field write value |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours, bit 7 PM in 12-hour mode |
| dow_o | output | 8 | Day of week |
| date_o | output | 8 | Day of month |
| month_o | output | 8 | Month |
| year_o | output | 8 | Year within century |
| uip_o | output | 1 | Update pending warning |

## Verification
The assertions take three things for granted:
- Every stored byte is a legal value in the selected encoding and hour format. The month-range and read-only-bit checks rely on this.
- The encoding and hour format change only while hold is high, with all fields then rewritten in the new form.
- `UIP_LEAD` is smaller than `TICK_DIV`.

The stimulus respects all three. It loads only valid calendar values, toggles `bin_mode` and `hour24` inside a hold window followed by a full reload, and runs the bench with `TICK_DIV` = 8 and `UIP_LEAD` = 2.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NFIELD = 7;
  localparam int BYTE_W = 8;
  localparam int IX_SEC = 0;
  localparam int IX_MIN = 1;
  localparam int IX_HR  = 2;
  localparam int IX_DOW = 3;
  localparam int IX_DAT = 4;
  localparam int IX_MON = 5;
  localparam int IX_YR  = 6;

  typedef logic [NFIELD-1:0][BYTE_W-1:0] bank_t;

  // decode a stored byte into a plain count 0..99
  function automatic logic [6:0] fdec(input logic [7:0] b, input logic bin);
    logic [6:0] t;
    if (bin) t = b[6:0];
    else     t = 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
    return t;
  endfunction

  // encode a plain count 0..99 into the selected byte format
  function automatic logic [7:0] fenc(input logic [6:0] v, input logic bin);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = v / 7'd10;
    ones = v % 7'd10;
    if (bin) return {1'b0, v};
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [6:0] month_len(input logic [6:0] mon, input logic [6:0] yr);
    if (mon == 7'd2) return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
    if (mon == 7'd4 || mon == 7'd6 || mon == 7'd9 || mon == 7'd11) return 7'd30;
    return 7'd31;
  endfunction

  function automatic logic [7:0] fld_reset(input int idx);
    if (idx == IX_DOW || idx == IX_DAT || idx == IX_MON) return 8'h01;
    return 8'h00;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICK_DIV = 32768,
  parameter int UIP_LEAD = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic [2:0] div_ctl,
  input  logic       set_hold,
  output logic       fire,
  output logic       uip
);
  localparam int CNT_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(TICK_DIV / 2);
  localparam logic [CNT_W-1:0] WARN = CNT_W'(TICK_DIV - UIP_LEAD);

  logic [CNT_W-1:0] cnt_q;
  logic run, clr;

  assign run = (div_ctl == 3'b010);
  assign clr = (div_ctl[2:1] == 2'b11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clr)          cnt_q <= HALF;
    else if (run && tick_en) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign fire = run && tick_en && !set_hold && (cnt_q == LAST);
  assign uip  = run && !set_hold && (cnt_q >= WARN);

  p_clear_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == HALF));
  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt_q));
  p_uip_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !uip);
endmodule

// File: rtl/rtc_advance.sv
module rtc_advance
  import rtc_pkg::*;
(
  input  bank_t cur,
  input  logic  bin_mode,
  input  logic  hour24,
  output bank_t nxt
);
  logic [6:0] s, mi, hr, dw, dt, mo, yr, mlen, h12;
  logic [7:0] htmp;
  logic pm, c_min, c_hr, c_day, c_mon;

  always_comb begin
    nxt   = cur;
    s     = fdec(cur[IX_SEC], bin_mode);
    mi    = fdec(cur[IX_MIN], bin_mode);
    hr    = fdec({1'b0, cur[IX_HR][6:0]}, bin_mode);
    pm    = cur[IX_HR][7];
    dw    = fdec(cur[IX_DOW], bin_mode);
    dt    = fdec(cur[IX_DAT], bin_mode);
    mo    = fdec(cur[IX_MON], bin_mode);
    yr    = fdec(cur[IX_YR], bin_mode);
    mlen  = month_len(mo, yr);
    c_min = (s >= 7'd59);
    c_hr  = c_min && (mi >= 7'd59);
    c_day = 1'b0;
    h12   = 7'd1;
    htmp  = 8'h00;

    nxt[IX_SEC] = fenc(c_min ? 7'd0 : s + 7'd1, bin_mode) & 8'h7F;
    if (c_min) nxt[IX_MIN] = fenc(c_hr ? 7'd0 : mi + 7'd1, bin_mode);

    if (c_hr) begin
      if (hour24) begin
        c_day      = (hr >= 7'd23);
        nxt[IX_HR] = fenc(c_day ? 7'd0 : hr + 7'd1, bin_mode);
      end else begin
        if (hr == 7'd11)      h12 = 7'd12;
        else if (hr >= 7'd12) h12 = 7'd1;
        else                  h12 = hr + 7'd1;
        htmp       = fenc(h12, bin_mode);
        c_day      = (hr == 7'd11) && pm;
        nxt[IX_HR] = {(hr == 7'd11) ? ~pm : pm, htmp[6:0]};
      end
    end

    c_mon = c_day && (dt >= mlen);
    if (c_day) begin
      nxt[IX_DOW] = fenc((dw >= 7'd7) ? 7'd1 : dw + 7'd1, bin_mode);
      nxt[IX_DAT] = fenc(c_mon ? 7'd1 : dt + 7'd1, bin_mode);
    end
    if (c_mon) begin
      nxt[IX_MON] = fenc((mo >= 7'd12) ? 7'd1 : mo + 7'd1, bin_mode);
      if (mo >= 7'd12) nxt[IX_YR] = fenc((yr >= 7'd99) ? 7'd0 : yr + 7'd1, bin_mode);
    end
  end
endmodule

// File: rtl/rtc_time_bank.sv
module rtc_time_bank
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic       uip,
  input  logic       set_hold,
  input  logic       bin_mode,
  input  logic       hour24,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output bank_t      fields
);
  bank_t nxt;

  rtc_advance u_adv (
    .cur      (fields),
    .bin_mode (bin_mode),
    .hour24   (hour24),
    .nxt      (nxt)
  );

  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    logic [7:0] q;
    logic       hit;
    assign hit = set_hold && wr_en && (wr_sel == 3'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= fld_reset(i);
      else if (hit)   q <= (i == IX_SEC) ? {1'b0, wr_data[6:0]} : wr_data;
      else if (fire)  q <= nxt[i];
    end
    assign fields[i] = q;
  end

  p_sec_msb_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fields[IX_SEC][7] == 1'b0);
  p_hold_still_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(set_hold) && !$past(wr_en)) |-> $stable(fields));
  p_warned_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((fields[IX_SEC] != $past(fields[IX_SEC])) && !$past(set_hold)) |-> $past(uip));
  p_month_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !set_hold |-> (fdec(fields[IX_MON], bin_mode) >= 7'd1 && fdec(fields[IX_MON], bin_mode) <= 7'd12));
endmodule

// File: rtl/rtc_update_engine.sv
module rtc_update_engine
  import rtc_pkg::*;
#(
  parameter int TICK_DIV = 32768,
  parameter int UIP_LEAD = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic [2:0] div_ctl,
  input  logic       set_hold,
  input  logic       bin_mode,
  input  logic       hour24,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic       uip_o
);
  logic  fire, uip;
  bank_t fields;

  rtc_prescaler #(.TICK_DIV(TICK_DIV), .UIP_LEAD(UIP_LEAD)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .div_ctl  (div_ctl),
    .set_hold (set_hold),
    .fire     (fire),
    .uip      (uip)
  );

  rtc_time_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .uip      (uip),
    .set_hold (set_hold),
    .bin_mode (bin_mode),
    .hour24   (hour24),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .fields   (fields)
  );

  assign sec_o   = fields[IX_SEC];
  assign min_o   = fields[IX_MIN];
  assign hour_o  = fields[IX_HR];
  assign dow_o   = fields[IX_DOW];
  assign date_o  = fields[IX_DAT];
  assign month_o = fields[IX_MON];
  assign year_o  = fields[IX_YR];
  assign uip_o   = uip;
endmodule

// File: tb/rtc_update_engine_test.sv
module rtc_update_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int T = 8;
  localparam int L = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [2:0] dv = 3'b010;
  logic set = 1'b0, bin = 1'b0, h24 = 1'b1, wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
  logic uip_o;

  int tests = 0;
  int fails = 0;
  logic [7:0] mr [7];
  int mp;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_update_engine #(.TICK_DIV(T), .UIP_LEAD(L)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick), .div_ctl(dv), .set_hold(set),
    .bin_mode(bin), .hour24(h24), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o), .date_o(date_o),
    .month_o(month_o), .year_o(year_o), .uip_o(uip_o)
  );

  function automatic int bd(logic [7:0] b);
    if (bin) return int'(b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] be(int v);
    if (bin) return 8'(v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic void model_step();
    int s, mi, h, dw, dt, mo, yr, len;
    logic p;
    s = bd(mr[0]);
    if (s != 59) begin mr[0] = be(s + 1); return; end
    mr[0] = be(0);
    mi = bd(mr[1]);
    if (mi != 59) begin mr[1] = be(mi + 1); return; end
    mr[1] = be(0);
    if (h24) begin
      h = bd(mr[2]);
      if (h != 23) begin mr[2] = be(h + 1); return; end
      mr[2] = be(0);
    end else begin
      p = mr[2][7];
      h = bd(mr[2] & 8'h7F);
      if (h == 12) begin mr[2] = be(1) | (p ? 8'h80 : 8'h00); return; end
      if (h != 11) begin mr[2] = be(h + 1) | (p ? 8'h80 : 8'h00); return; end
      mr[2] = be(12) | (p ? 8'h00 : 8'h80);
      if (!p) return;
    end
    dw = bd(mr[3]);
    mr[3] = be(dw == 7 ? 1 : dw + 1);
    dt = bd(mr[4]); mo = bd(mr[5]); yr = bd(mr[6]);
    if (mo == 2) len = (yr % 4 == 0) ? 29 : 28;
    else if (mo == 4 || mo == 6 || mo == 9 || mo == 11) len = 30;
    else len = 31;
    if (dt < len) begin mr[4] = be(dt + 1); return; end
    mr[4] = be(1);
    if (mo < 12) begin mr[5] = be(mo + 1); return; end
    mr[5] = be(1);
    mr[6] = be(yr == 99 ? 0 : yr + 1);
  endfunction

  always @(posedge clk) begin
    logic go;
    if (!rst_n) begin
      mr = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
      mp = 0;
    end else begin
      go = tick && (dv == 3'b010) && !set && (mp == T - 1);
      if (dv[2:1] == 2'b11) mp = T / 2;
      else if (dv == 3'b010 && tick) mp = (mp + 1) % T;
      if (set && wr_en) mr[wr_sel] = (wr_sel == 3'd0) ? (wr_data & 8'h7F) : wr_data;
      else if (go) model_step();
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    logic eu;
    eu = (dv == 3'b010) && !set && (mp >= T - L);
    check("R1 seconds", sec_o, mr[0]);
    check("R2 minutes", min_o, mr[1]);
    check("R3 hours", hour_o, mr[2]);
    check("R5 day of week", dow_o, mr[3]);
    check("R6 date", date_o, mr[4]);
    check("R7 month", month_o, mr[5]);
    check("R7 year", year_o, mr[6]);
    check("R9 uip", 8'(uip_o), 8'(eu));
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rst_n) compare_all();
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic load(logic [7:0] h, logic [7:0] mi, logic [7:0] s, logic [7:0] dw,
                      logic [7:0] dt, logic [7:0] mo, logic [7:0] yr);
    set = 1'b1;
    wr(3'd0, s); wr(3'd1, mi); wr(3'd2, h); wr(3'd3, dw);
    wr(3'd4, dt); wr(3'd5, mo); wr(3'd6, yr);
    set = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] s0;
    int k;
    cyc(2);
    @(negedge clk);
    check("R12 reset sec", sec_o, 8'h00);
    check("R12 reset hour", hour_o, 8'h00);
    check("R12 reset dow", dow_o, 8'h01);
    check("R12 reset date", date_o, 8'h01);
    check("R12 reset month", month_o, 8'h01);
    check("R12 reset uip", 8'(uip_o), 8'h00);
    rst_n = 1'b1; tick = 1'b1;
    cyc(3 * T);

    // BCD 24h, non-leap February end at midnight
    load(8'h23, 8'h59, 8'h57, 8'h07, 8'h28, 8'h02, 8'h23);
    cyc(4 * T);
    check("R3 midnight hour", hour_o, 8'h00);
    check("R5 dow wrap", dow_o, 8'h01);
    check("R6 feb28 nonleap date", date_o, 8'h01);
    check("R6 feb28 nonleap month", month_o, 8'h03);

    load(8'h23, 8'h59, 8'h59, 8'h03, 8'h28, 8'h02, 8'h24);
    cyc(2 * T);
    check("R6 leap feb29", date_o, 8'h29);
    load(8'h23, 8'h59, 8'h59, 8'h04, 8'h29, 8'h02, 8'h24);
    cyc(2 * T);
    check("R6 leap to march", month_o, 8'h03);
    load(8'h23, 8'h59, 8'h59, 8'h02, 8'h28, 8'h02, 8'h00);
    cyc(2 * T);
    check("R6 year 00 leap", date_o, 8'h29);
    load(8'h23, 8'h59, 8'h59, 8'h05, 8'h30, 8'h04, 8'h10);
    cyc(2 * T);
    check("R6 april end", month_o, 8'h05);
    load(8'h23, 8'h59, 8'h59, 8'h06, 8'h31, 8'h12, 8'h99);
    cyc(2 * T);
    check("R7 year wrap", year_o, 8'h00);
    check("R7 month wrap", month_o, 8'h01);

    // binary encoding
    set = 1'b1; bin = 1'b1; cyc(1);
    load(8'd23, 8'd59, 8'd58, 8'd1, 8'd31, 8'd1, 8'd5);
    cyc(3 * T);
    check("R2 binary month", month_o, 8'd2);
    check("R2 binary date", date_o, 8'd1);

    // 12-hour BCD
    set = 1'b1; bin = 1'b0; h24 = 1'b0; cyc(1);
    load(8'h11, 8'h59, 8'h59, 8'h01, 8'h10, 8'h06, 8'h30);
    cyc(2 * T);
    check("R4 11am to 12pm", hour_o, 8'h92);
    load(8'h91, 8'h59, 8'h59, 8'h01, 8'h15, 8'h06, 8'h30);
    cyc(2 * T);
    check("R4 11pm to 12am", hour_o, 8'h12);
    check("R4 new day", date_o, 8'h16);
    load(8'h92, 8'h59, 8'h59, 8'h01, 8'h15, 8'h06, 8'h30);
    cyc(2 * T);
    check("R4 12pm to 1pm", hour_o, 8'h81);

    // tick gaps
    for (int i = 0; i < 6 * T; i++) begin tick = ~tick; cyc(1); end
    tick = 1'b1;

    // divider preset and release
    dv = 3'b110; cyc(4);
    dv = 3'b010;
    s0 = sec_o; k = 0;
    do begin cyc(1); k++; end while (sec_o == s0 && k < 100);
    check("R8 half-second first update", 8'(k), 8'(T / 2));
    s0 = sec_o; k = 0;
    do begin cyc(1); k++; end while (sec_o == s0 && k < 100);
    check("R1 update period", 8'(k), 8'(T));

    // uip lead
    k = 0;
    while (!uip_o && k < 100) begin cyc(1); k++; end
    s0 = sec_o; k = 0;
    while (uip_o && k < 100) begin cyc(1); k++; end
    check("R9 uip width", 8'(k), 8'(L));
    check("R9 change after uip", 8'(sec_o != s0), 8'h01);

    // freeze
    dv = 3'b000; cyc(1); s0 = sec_o;
    cyc(3 * T);
    check("R8 frozen", sec_o, s0);
    dv = 3'b010;

    // writes without hold, hold stall, read-only bit
    wr(3'd0, 8'h33);
    check("R10 ignored write", sec_o, mr[0]);
    set = 1'b1; cyc(1); s0 = sec_o;
    cyc(3 * T);
    check("R10 hold stall", sec_o, s0);
    wr(3'd0, 8'hD5);
    check("R11 seconds msb", sec_o, 8'h55);
    set = 1'b0;
    cyc(2 * T);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule